// File: doc/BRIEF.md
# Fully associative LRU stack tag store

This block is the tag side of a single-set, fully associative cache. All entries sit in one recency stack. Slot 0 holds the most recently used block and the last slot holds the least recently used one. A request carries a byte address and an operation code. The block drops the in-block offset bits and compares the remaining tag against every slot in one cycle. It answers one cycle later with hit or miss, the physical way index of the entry, and a residency mask.

The residency mask turns the stack into a stack-distance profiler. Bit k of the mask says whether the block would also have hit in a smaller store of `BASE << k` entries under the same replacement order. Counters kept for each tracked capacity, and one for the full store, let a single pass model several cache sizes at once.

An access that misses takes the least recent slot, writes the new tag at the most recent end and pushes every other entry back by one. A find-only lookup leaves the order untouched. An invalidation clears an entry and parks it at the least recent end, so it is the next victim. A walk operation streams every way in index order and can be cut short by the requester.

Top module: `lru_stk_tags`

## Requirements
- R1: After reset the store is idle and empty:
  - every entry is invalid and `req_ready` is 1;
  - `rsp_valid` and `walk_valid` are 0;
  - all counters are zero;
  - stack slot i holds way i.
- R2: The tag is `req_addr` with its low `OFFS_W` bits ignored, so two addresses in the same block match the same entry. The walk reports the block address with those bits zero.
- R3: An access (op 0) that hits answers with `rsp_hit`=1 and `rsp_idx` = the matching way. The entry moves to stack slot 0. Entries that were above it shift down by one slot.
- R4: An access that misses evicts the entry in the last stack slot and refills that way at slot 0 with the new tag. It answers `rsp_hit`=0, `rsp_idx` = the refilled way and `rsp_mask`=0. The first allocation after reset uses way `ENTRIES-1`. Way indices always form a permutation of the slots.
- R5: On any hit, `rsp_mask` bit k is 1 exactly when the entry's stack slot before the request is below `BASE << k`, with slot 0 the most recent. A set bit k therefore implies bit k+1 is set.
- R6: A find (op 1) answers like an access hit or miss, with a zero index on a miss. It changes neither the stack order, the touched flags nor any counter.
- R7: An invalidate (op 2) that matches clears the entry's valid and touched flags and moves it to the last stack slot. The next miss reuses it. It answers `rsp_hit`=1 with the way and the mask. When nothing matches it answers hit 0, index 0, mask 0 and changes nothing. Valid entries always occupy a prefix of the stack.
- R8: An invalid entry never matches, even when its old tag equals the request.
- R9: Each access adds one to `acc_cnt`. For every tracked size k below `NSZ`, counter k is bits `[k*CNT_W +: CNT_W]` of the bus. A hit with mask bit k adds one to `hit_cnt` counter k; any other access adds one to `miss_cnt` counter k. Counter `NSZ` counts full-store hits and misses. Other operations leave all counters unchanged.
- R10: An entry's touched flag is 0 when it is filled and becomes 1 on an access hit to it.
- R11: A walk (op 3) drives `walk_valid` from the cycle after acceptance, delivering ways 0, 1, 2, … one per cycle. Each cycle reports that way's block address, valid flag and touched flag.
  - The walk ends after way `ENTRIES-1`, or after the cycle in which `walk_stop` is 1.
  - `req_ready` is 0 while the walk runs.
  - A walk produces no response.
- R12: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Exactly one cycle later `rsp_valid` is 1 for every taken operation other than a walk, and it is 0 at all other times. Operation codes: 0 access, 1 find, 2 invalidate, 3 walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (low during a walk) |
| req_op | input | 2 | Operation: 0 access, 1 find, 2 invalidate, 3 walk |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_valid | output | 1 | Response for the request taken on the previous edge |
| rsp_hit | output | 1 | Block was present |
| rsp_idx | output | log2(ENTRIES) | Way of the hit, or way refilled on an access miss |
| rsp_mask | output | log2(ENTRIES/BASE) | Smaller capacities that also hold the block |
| walk_stop | input | 1 | End the walk after the current way |
| walk_valid | output | 1 | Walk output valid |
| walk_idx | output | log2(ENTRIES) | Way being reported |
| walk_addr | output | ADDR_W | Block address stored in that way |
| walk_live | output | 1 | Valid flag of that way |
| walk_touched | output | 1 | Touched flag of that way |
| acc_cnt | output | CNT_W | Total accesses |
| hit_cnt | output | (NSZ+1)*CNT_W | Hits per tracked capacity, full store on top |
| miss_cnt | output | (NSZ+1)*CNT_W | Misses per tracked capacity, full store on top |

## Verification
The bound checker holds several rules on every cycle:
- the stack always carries a permutation of way indices;
- valid entries stay a prefix of the stack;
- a find never disturbs the order;
- responses come exactly one cycle after acceptance, and a miss has an empty mask;
- hit masks are thermometer shaped;
- the total counter moves only on accesses;
- a walk advances one way per cycle and ends as specified.

Whether the right way was chosen, where each entry ended up in the stack, the exact mask and counter values, and the reuse of invalidated ways can only be shown by the bench. Its behavioural queue model is run through fills, deep hits, find-only probes, invalidations, full and truncated walks and a long pseudo-random mix.

// File: rtl/lru_stk_pkg.sv
package lru_stk_pkg;

   // request operation codes (R12)
   typedef enum logic [1:0] {
      OP_ACCESS = 2'd0,
      OP_FIND   = 2'd1,
      OP_INVAL  = 2'd2,
      OP_WALK   = 2'd3
   } stk_op_e;

endpackage

// File: rtl/lru_stk_match.sv
// Parallel tag compare over all stack slots, slot position of the match and
// the residency mask derived from that position.
module lru_stk_match #(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 26,
   parameter int BASE    = 2,
   parameter int IDX_W   = 4,
   parameter int NSZ     = 3
) (
   input  logic [ENTRIES*TAG_W-1:0] slot_tag_i,
   input  logic [ENTRIES-1:0]       slot_valid_i,
   input  logic [TAG_W-1:0]         key_i,
   output logic                     hit_o,
   output logic [IDX_W-1:0]         pos_o,
   output logic [NSZ-1:0]           mask_o
);

   logic [ENTRIES-1:0] eq;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
         assign eq[i] = slot_valid_i[i] && (slot_tag_i[i*TAG_W +: TAG_W] == key_i);
      end
   endgenerate

   always_comb begin
      hit_o = |eq;
      pos_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (eq[i]) pos_o = IDX_W'(i);
      end
   end

   generate
      for (genvar k = 0; k < NSZ; k++) begin : g_res
         localparam int LIMIT = BASE << k;
         assign mask_o[k] = hit_o && (int'(pos_o) < LIMIT);
      end
   endgenerate

endmodule

// File: rtl/lru_stk_order.sv
// Recency stack: slot 0 is most recent. Supports move-to-front (with optional
// refill) and move-to-back (invalidate) of one slot per cycle.
module lru_stk_order #(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 26,
   parameter int IDX_W   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     to_front_i,
   input  logic                     to_back_i,
   input  logic [IDX_W-1:0]         pos_i,
   input  logic                     fill_i,
   input  logic [TAG_W-1:0]         tag_i,
   output logic [ENTRIES*TAG_W-1:0] slot_tag_o,
   output logic [ENTRIES-1:0]       slot_valid_o,
   output logic [ENTRIES-1:0]       slot_touch_o,
   output logic [ENTRIES*IDX_W-1:0] slot_id_o
);

   localparam int LAST = ENTRIES - 1;

   logic [TAG_W-1:0] tag_q [ENTRIES];
   logic [TAG_W-1:0] tag_d [ENTRIES];
   logic [IDX_W-1:0] id_q  [ENTRIES];
   logic [IDX_W-1:0] id_d  [ENTRIES];
   logic             val_q [ENTRIES];
   logic             val_d [ENTRIES];
   logic             tch_q [ENTRIES];
   logic             tch_d [ENTRIES];

   always_comb begin
      int src;
      for (int i = 0; i < ENTRIES; i++) begin
         src = i;
         if (to_front_i) begin
            if (i == 0)                src = int'(pos_i);
            else if (i <= int'(pos_i)) src = i - 1;
         end else if (to_back_i) begin
            if (i == LAST)             src = int'(pos_i);
            else if (i >= int'(pos_i)) src = i + 1;
         end
         tag_d[i] = tag_q[src];
         id_d[i]  = id_q[src];
         val_d[i] = val_q[src];
         tch_d[i] = tch_q[src];
      end
      if (to_front_i) begin
         if (fill_i) begin
            tag_d[0] = tag_i;
            val_d[0] = 1'b1;
            tch_d[0] = 1'b0;
         end else begin
            tch_d[0] = 1'b1;
         end
      end
      if (to_back_i) begin
         val_d[LAST] = 1'b0;
         tch_d[LAST] = 1'b0;
      end
   end

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tag_q[i] <= '0;
               id_q[i]  <= IDX_W'(i);
               val_q[i] <= 1'b0;
               tch_q[i] <= 1'b0;
            end else begin
               tag_q[i] <= tag_d[i];
               id_q[i]  <= id_d[i];
               val_q[i] <= val_d[i];
               tch_q[i] <= tch_d[i];
            end
         end
         assign slot_tag_o[i*TAG_W +: TAG_W] = tag_q[i];
         assign slot_id_o[i*IDX_W +: IDX_W]  = id_q[i];
         assign slot_valid_o[i]              = val_q[i];
         assign slot_touch_o[i]              = tch_q[i];
      end
   endgenerate

endmodule

// File: rtl/lru_stk_stats.sv
// Per-capacity hit/miss counters plus the total access counter.
module lru_stk_stats #(
   parameter int NSZ   = 3,
   parameter int CNT_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     count_i,
   input  logic                     hit_i,
   input  logic [NSZ-1:0]           mask_i,
   output logic [CNT_W-1:0]         acc_o,
   output logic [(NSZ+1)*CNT_W-1:0] hit_o,
   output logic [(NSZ+1)*CNT_W-1:0] miss_o
);

   logic [NSZ:0]     in_size;
   logic [CNT_W-1:0] acc_q;

   assign in_size = {hit_i, mask_i};

   always_ff @(posedge clk) begin
      if (!rst_n)       acc_q <= '0;
      else if (count_i) acc_q <= acc_q + 1'b1;
   end
   assign acc_o = acc_q;

   generate
      for (genvar k = 0; k <= NSZ; k++) begin : g_size
         logic [CNT_W-1:0] hq;
         logic [CNT_W-1:0] mq;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hq <= '0;
               mq <= '0;
            end else if (count_i) begin
               if (in_size[k]) hq <= hq + 1'b1;
               else            mq <= mq + 1'b1;
            end
         end
         assign hit_o[k*CNT_W +: CNT_W]  = hq;
         assign miss_o[k*CNT_W +: CNT_W] = mq;
      end
   endgenerate

endmodule

// File: rtl/lru_stk_walk.sv
// Walks all ways in index order, one per cycle, with early termination.
module lru_stk_walk #(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 26,
   parameter int IDX_W   = 4,
   parameter int OFFS_W  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     stop_i,
   input  logic [ENTRIES*TAG_W-1:0] slot_tag_i,
   input  logic [ENTRIES-1:0]       slot_valid_i,
   input  logic [ENTRIES-1:0]       slot_touch_i,
   input  logic [ENTRIES*IDX_W-1:0] slot_id_i,
   output logic                     busy_o,
   output logic [IDX_W-1:0]         idx_o,
   output logic [TAG_W+OFFS_W-1:0]  addr_o,
   output logic                     live_o,
   output logic                     touch_o
);

   localparam logic [IDX_W-1:0] LAST_ID = IDX_W'(ENTRIES - 1);

   logic             busy_q;
   logic [IDX_W-1:0] ptr_q;
   logic [TAG_W-1:0] sel_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ptr_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         ptr_q  <= '0;
      end else if (busy_q) begin
         if (stop_i || ptr_q == LAST_ID) busy_q <= 1'b0;
         else                            ptr_q  <= ptr_q + 1'b1;
      end
   end

   always_comb begin
      sel_tag = '0;
      live_o  = 1'b0;
      touch_o = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (slot_id_i[i*IDX_W +: IDX_W] == ptr_q) begin
            sel_tag = slot_tag_i[i*TAG_W +: TAG_W];
            live_o  = slot_valid_i[i];
            touch_o = slot_touch_i[i];
         end
      end
   end

   assign busy_o = busy_q;
   assign idx_o  = ptr_q;
   assign addr_o = {sel_tag, {OFFS_W{1'b0}}};

endmodule

// File: rtl/lru_stk_tags.sv
module lru_stk_tags
   import lru_stk_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OFFS_W  = 6,
   parameter int ENTRIES = 16,
   parameter int BASE    = 2,
   parameter int CNT_W   = 16,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int NSZ    = $clog2(ENTRIES / BASE)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [1:0]               req_op,
   input  logic [ADDR_W-1:0]        req_addr,
   output logic                     rsp_valid,
   output logic                     rsp_hit,
   output logic [IDX_W-1:0]         rsp_idx,
   output logic [NSZ-1:0]           rsp_mask,
   input  logic                     walk_stop,
   output logic                     walk_valid,
   output logic [IDX_W-1:0]         walk_idx,
   output logic [ADDR_W-1:0]        walk_addr,
   output logic                     walk_live,
   output logic                     walk_touched,
   output logic [CNT_W-1:0]         acc_cnt,
   output logic [(NSZ+1)*CNT_W-1:0] hit_cnt,
   output logic [(NSZ+1)*CNT_W-1:0] miss_cnt
);

   localparam int TAG_W = ADDR_W - OFFS_W;
   localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(ENTRIES - 1);

   // elaboration-time parameter checks
   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("ENTRIES must be a power of two of at least 2");
      end
      if (BASE < 1 || (BASE & (BASE - 1)) != 0 || BASE >= ENTRIES) begin : g_bad_base
         $error("BASE must be a power of two below ENTRIES");
      end
      if (OFFS_W < 1 || OFFS_W >= ADDR_W) begin : g_bad_offs
         $error("OFFS_W must lie between 1 and ADDR_W-1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   stk_op_e              op_w;
   logic                 accept;
   logic                 do_access;
   logic                 do_inval;
   logic                 do_walk;
   logic [TAG_W-1:0]     key;
   logic                 unused_offs;

   logic [ENTRIES*TAG_W-1:0] slot_tags;
   logic [ENTRIES-1:0]       slot_valid;
   logic [ENTRIES-1:0]       slot_touch;
   logic [ENTRIES*IDX_W-1:0] slot_ids;

   logic                 m_hit;
   logic [IDX_W-1:0]     m_pos;
   logic [NSZ-1:0]       m_mask;
   logic [IDX_W-1:0]     sel_pos;
   logic                 walk_busy;
   logic [TAG_W+OFFS_W-1:0] walk_addr_w;

   assign op_w        = stk_op_e'(req_op);
   assign accept      = req_valid && req_ready;
   assign do_access   = accept && (op_w == OP_ACCESS);
   assign do_inval    = accept && (op_w == OP_INVAL);
   assign do_walk     = accept && (op_w == OP_WALK);
   assign key         = req_addr[ADDR_W-1:OFFS_W];
   assign unused_offs = ^req_addr[OFFS_W-1:0];
   assign req_ready   = !walk_busy;

   lru_stk_match #(
      .ENTRIES(ENTRIES), .TAG_W(TAG_W), .BASE(BASE), .IDX_W(IDX_W), .NSZ(NSZ)
   ) u_match (
      .slot_tag_i  (slot_tags),
      .slot_valid_i(slot_valid),
      .key_i       (key),
      .hit_o       (m_hit),
      .pos_o       (m_pos),
      .mask_o      (m_mask)
   );

   // a miss promotes the least recent slot, which is then refilled
   assign sel_pos = m_hit ? m_pos : LAST_POS;

   lru_stk_order #(
      .ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)
   ) u_order (
      .clk         (clk),
      .rst_n       (rst_n),
      .to_front_i  (do_access),
      .to_back_i   (do_inval && m_hit),
      .pos_i       (sel_pos),
      .fill_i      (!m_hit),
      .tag_i       (key),
      .slot_tag_o  (slot_tags),
      .slot_valid_o(slot_valid),
      .slot_touch_o(slot_touch),
      .slot_id_o   (slot_ids)
   );

   lru_stk_stats #(
      .NSZ(NSZ), .CNT_W(CNT_W)
   ) u_stats (
      .clk    (clk),
      .rst_n  (rst_n),
      .count_i(do_access),
      .hit_i  (m_hit),
      .mask_i (m_mask),
      .acc_o  (acc_cnt),
      .hit_o  (hit_cnt),
      .miss_o (miss_cnt)
   );

   lru_stk_walk #(
      .ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFFS_W(OFFS_W)
   ) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (do_walk),
      .stop_i      (walk_stop),
      .slot_tag_i  (slot_tags),
      .slot_valid_i(slot_valid),
      .slot_touch_i(slot_touch),
      .slot_id_i   (slot_ids),
      .busy_o      (walk_busy),
      .idx_o       (walk_idx),
      .addr_o      (walk_addr_w),
      .live_o      (walk_live),
      .touch_o     (walk_touched)
   );

   assign walk_valid = walk_busy;
   assign walk_addr  = walk_addr_w;

   // registered response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_idx   <= '0;
         rsp_mask  <= '0;
      end else begin
         rsp_valid <= accept && (op_w != OP_WALK);
         if (accept && (op_w != OP_WALK)) begin
            rsp_hit  <= m_hit;
            rsp_mask <= m_mask;
            if (m_hit || do_access) rsp_idx <= slot_ids[sel_pos*IDX_W +: IDX_W];
            else                    rsp_idx <= '0;
         end
      end
   end

endmodule

// File: rtl/lru_stk_chk.sv
module lru_stk_chk #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int NSZ     = 3,
   parameter int CNT_W   = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_ready,
   input logic [1:0]               req_op,
   input logic                     rsp_valid,
   input logic                     rsp_hit,
   input logic [NSZ-1:0]           rsp_mask,
   input logic                     walk_valid,
   input logic [IDX_W-1:0]         walk_idx,
   input logic                     walk_stop,
   input logic [CNT_W-1:0]         acc_cnt,
   input logic [ENTRIES-1:0]       slot_valid,
   input logic [ENTRIES*IDX_W-1:0] slot_ids
);

   localparam logic [IDX_W-1:0] LAST_ID = IDX_W'(ENTRIES - 1);

   logic               take;
   logic               take_rsp;
   logic               take_acc;
   logic               take_find;
   logic [ENTRIES-1:0] ids_seen;
   logic               prefix_ok;
   logic               thermo_ok;

   assign take      = req_valid && req_ready;
   assign take_rsp  = take && (req_op != 2'd3);
   assign take_acc  = take && (req_op == 2'd0);
   assign take_find = take && (req_op == 2'd1);

   always_comb begin
      ids_seen = '0;
      for (int i = 0; i < ENTRIES; i++) ids_seen[slot_ids[i*IDX_W +: IDX_W]] = 1'b1;
   end

   always_comb begin
      prefix_ok = 1'b1;
      for (int i = 0; i < ENTRIES - 1; i++) begin
         if (!slot_valid[i] && slot_valid[i+1]) prefix_ok = 1'b0;
      end
   end

   always_comb begin
      thermo_ok = 1'b1;
      for (int k = 0; k < NSZ - 1; k++) begin
         if (rsp_mask[k] && !rsp_mask[k+1]) thermo_ok = 1'b0;
      end
   end

   p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      take_rsp |=> rsp_valid);
   p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !take_rsp |=> !rsp_valid);
   p_ready_walk_r11: assert property (@(posedge clk) disable iff (!rst_n)
      walk_valid |-> !req_ready);
   p_walk_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_valid && !walk_stop && walk_idx != LAST_ID) |=>
         (walk_valid && walk_idx == IDX_W'($past(walk_idx) + 1'b1)));
   p_walk_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_valid && (walk_stop || walk_idx == LAST_ID)) |=> !walk_valid);
   p_miss_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_mask == '0));
   p_mask_thermo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> thermo_ok);
   p_acc_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take_acc |=> (acc_cnt == CNT_W'($past(acc_cnt) + 1'b1)));
   p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !take_acc |=> $stable(acc_cnt));
   p_find_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_find |=> ($stable(slot_ids) && $stable(slot_valid)));
   p_valid_prefix_r7: assert property (@(posedge clk) disable iff (!rst_n)
      prefix_ok);
   p_ids_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ids_seen == '1);

endmodule

bind lru_stk_tags lru_stk_chk #(
   .ENTRIES(ENTRIES), .IDX_W(IDX_W), .NSZ(NSZ), .CNT_W(CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_op    (req_op),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_mask  (rsp_mask),
   .walk_valid(walk_valid),
   .walk_idx  (walk_idx),
   .walk_stop (walk_stop),
   .acc_cnt   (acc_cnt),
   .slot_valid(slot_valid),
   .slot_ids  (slot_ids)
);

// File: tb/test_lru_stk_tags.sv
`timescale 1ns/1ps
module test_lru_stk_tags;

   localparam int ADDR_W  = 32;
   localparam int OFFS_W  = 6;
   localparam int ENTRIES = 16;
   localparam int BASE    = 2;
   localparam int CNT_W   = 16;
   localparam int IDX_W   = 4;
   localparam int NSZ     = 3;
   localparam int NCNT    = NSZ + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic                    req_valid = 1'b0;
   logic                    req_ready;
   logic [1:0]              req_op = 2'd0;
   logic [ADDR_W-1:0]       req_addr = '0;
   logic                    rsp_valid, rsp_hit;
   logic [IDX_W-1:0]        rsp_idx;
   logic [NSZ-1:0]          rsp_mask;
   logic                    walk_stop = 1'b0;
   logic                    walk_valid, walk_live, walk_touched;
   logic [IDX_W-1:0]        walk_idx;
   logic [ADDR_W-1:0]       walk_addr;
   logic [CNT_W-1:0]        acc_cnt;
   logic [NCNT*CNT_W-1:0]   hit_cnt, miss_cnt;

   lru_stk_tags #(
      .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .ENTRIES(ENTRIES), .BASE(BASE), .CNT_W(CNT_W)
   ) i_lru_stk_tags (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_idx(rsp_idx), .rsp_mask(rsp_mask), .walk_stop(walk_stop),
      .walk_valid(walk_valid), .walk_idx(walk_idx), .walk_addr(walk_addr),
      .walk_live(walk_live), .walk_touched(walk_touched), .acc_cnt(acc_cnt),
      .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit mon_on = 1'b0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int                ord[$];            // way ids, most recent first
   logic [ADDR_W-1:0] mtag [ENTRIES];
   bit                mval [ENTRIES];
   bit                mtch [ENTRIES];
   int                m_acc;
   int                m_hit [NCNT];
   int                m_miss[NCNT];
   bit                e_v;
   bit                e_hit;
   int                e_idx;
   int                e_mask;
   string             e_req;
   bit                m_walk_pend, m_walking;
   int                m_wptr;

   function automatic logic [ADDR_W-1:0] align(logic [ADDR_W-1:0] a);
      return a & ~((ADDR_W'(1) << OFFS_W) - 1);
   endfunction

   function automatic void model_reset();
      ord = {};
      for (int i = 0; i < ENTRIES; i++) begin
         ord.push_back(i);
         mtag[i] = '0; mval[i] = 0; mtch[i] = 0;
      end
      m_acc = 0;
      for (int k = 0; k < NCNT; k++) begin m_hit[k] = 0; m_miss[k] = 0; end
      e_v = 0; m_walk_pend = 0; m_walking = 0; m_wptr = 0;
   endfunction

   function automatic int find_pos(logic [ADDR_W-1:0] a);
      for (int p = 0; p < ord.size(); p++)
         if (mval[ord[p]] && mtag[ord[p]] == align(a)) return p;
      return -1;
   endfunction

   function automatic void model_req(int op, logic [ADDR_W-1:0] a);
      int p;
      int w;
      p = find_pos(a);
      e_v = (op != 3); e_hit = (p >= 0); e_idx = 0; e_mask = 0;
      if (p >= 0) begin
         w = ord[p];
         e_idx = w;
         for (int k = 0; k < NSZ; k++) if (p < (BASE << k)) e_mask |= (1 << k);
      end
      case (op)
         0: begin
            e_req = (p >= 0) ? "R3" : "R4";
            m_acc++;
            for (int k = 0; k < NSZ; k++)
               if (p >= 0 && p < (BASE << k)) m_hit[k]++; else m_miss[k]++;
            if (p >= 0) m_hit[NSZ]++; else m_miss[NSZ]++;
            if (p >= 0) begin
               ord.delete(p); ord.push_front(w); mtch[w] = 1;
            end else begin
               w = ord.pop_back(); ord.push_front(w);
               mtag[w] = align(a); mval[w] = 1; mtch[w] = 0; e_idx = w;
            end
         end
         1: e_req = "R6";
         2: begin
            e_req = "R7";
            if (p >= 0) begin
               ord.delete(p); ord.push_back(w); mval[w] = 0; mtch[w] = 0;
            end
         end
         default: m_walk_pend = 1;
      endcase
   endfunction

   // per-cycle comparison, 1 ns after each rising edge
   always @(posedge clk) begin
      #1;
      if (mon_on) begin
         if (m_walk_pend) begin
            m_walking = 1; m_wptr = 0; m_walk_pend = 0;
         end else if (m_walking) begin
            if (walk_stop || m_wptr == ENTRIES - 1) m_walking = 0;
            else m_wptr++;
         end
         chk(rsp_valid == e_v, "R12", "rsp_valid", rsp_valid, e_v);
         if (e_v && rsp_valid) begin
            chk(rsp_hit == e_hit, e_req, "rsp_hit", rsp_hit, e_hit);
            chk(int'(rsp_idx) == e_idx, e_req, "rsp_idx", rsp_idx, e_idx);
            chk(int'(rsp_mask) == e_mask, "R5", "rsp_mask", rsp_mask, e_mask);
         end
         e_v = 0;
         chk(int'(acc_cnt) == m_acc, "R9", "acc_cnt", acc_cnt, m_acc);
         for (int k = 0; k < NCNT; k++) begin
            chk(int'(hit_cnt[k*CNT_W +: CNT_W]) == m_hit[k], "R9", $sformatf("hit_cnt[%0d]", k),
                hit_cnt[k*CNT_W +: CNT_W], m_hit[k]);
            chk(int'(miss_cnt[k*CNT_W +: CNT_W]) == m_miss[k], "R9", $sformatf("miss_cnt[%0d]", k),
                miss_cnt[k*CNT_W +: CNT_W], m_miss[k]);
         end
         chk(req_ready == !m_walking, "R11", "req_ready", req_ready, !m_walking);
         chk(walk_valid == m_walking, "R11", "walk_valid", walk_valid, m_walking);
         if (m_walking && walk_valid) begin
            chk(int'(walk_idx) == m_wptr, "R11", "walk_idx", walk_idx, m_wptr);
            chk(walk_live == mval[m_wptr], "R11", "walk_live", walk_live, mval[m_wptr]);
            chk(walk_touched == mtch[m_wptr], "R10", "walk_touched", walk_touched, mtch[m_wptr]);
            if (mval[m_wptr])
               chk(walk_addr == mtag[m_wptr], "R2", "walk_addr", walk_addr, mtag[m_wptr]);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic issue(int op, logic [ADDR_W-1:0] a);
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = 2'(op);
      req_addr  = a;
      model_req(op, a);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // walk; stop_at < 0 means run to the end
   task automatic walk(int stop_at);
      issue(3, '0);
      for (int i = 0; i < ENTRIES; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
         walk_stop = (i == stop_at);
         if (i == stop_at) break;
      end
      @(negedge clk);
      walk_stop = 1'b0;
      idle(1);
   endtask

   function automatic logic [ADDR_W-1:0] blk(int n, int off);
      return ADDR_W'(n) * (ADDR_W'(1) << OFFS_W) + ADDR_W'(off);
   endfunction

   logic [31:0] lf = 32'h1ace_b00c;
   function automatic logic [31:0] rnd();
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      return lf;
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      #(4 * 100000);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
      chk(walk_valid == 1'b0, "R1", "walk_valid", walk_valid, 0);
      chk(acc_cnt == '0 && hit_cnt == '0 && miss_cnt == '0, "R1", "counters", acc_cnt, 0);
      mon_on = 1'b1;
      walk(-1);                                 // R1: all ways empty

      // fill the store: R4, ways taken from the top index down
      for (int i = 0; i < ENTRIES; i++) issue(0, blk(i + 1, i));
      idle(1);
      // hits at several depths, other offsets in the same block (R2, R3, R5)
      issue(0, blk(1, 63));                     // deepest slot
      issue(0, blk(16, 1));
      issue(0, blk(12, 5));
      issue(0, blk(1, 0));                      // now at slot 2
      issue(0, blk(9, 7));
      idle(1);
      walk(-1);                                 // R2, R10 touched flags

      // find-only leaves order alone (R6)
      issue(1, blk(2, 0));                      // least recent block
      issue(1, blk(40, 0));                     // miss
      issue(0, blk(40, 0));                     // evicts block 2
      issue(1, blk(2, 0));                      // now a miss
      idle(1);

      // invalidation (R7, R8)
      issue(2, blk(12, 3));
      issue(1, blk(12, 0));
      @(posedge clk); #1.5;
      chk(rsp_valid && !rsp_hit, "R8", "find after invalidate", rsp_hit, 0);
      issue(2, blk(77, 0));                     // no match
      issue(0, blk(50, 0));                     // reuses the invalidated way
      issue(0, blk(12, 0));                     // miss again
      idle(1);

      // truncated walks (R11)
      walk(5);
      walk(0);
      walk(ENTRIES - 1);

      // pseudo-random mix
      for (int n = 0; n < 400; n++) begin
         logic [31:0] r;
         int op;
         r = rnd();
         op = (r[3:0] < 10) ? 0 : (r[3:0] < 13) ? 1 : 2;
         issue(op, blk(int'(r[12:8]) % 24 + 1, int'(r[21:16])));
         if (r[27:24] == 0) idle(1);
         if (n % 100 == 99) begin idle(1); walk(int'(r[31:28]) - 4); end
      end
      idle(2);
      walk(-1);
      idle(2);

      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule